// File: doc/BRIEF.md
# Max-Log-MAP Soft Demapper Core

This block turns one received complex symbol into a set of signed bit reliabilities, using the max-log approximation. The constellation reaches it as a stream of points, one per clock cycle, and each point carries its I and Q coordinates and its bit label. The received sample, the separate I and Q fading gains, and a precomputed noise weight equal to 1/(2σ²) are held steady for the whole symbol. For every point the core forms a weighted squared distance. In iterative operation it also subtracts the feedback LLRs of the other bits that the label selects. Eight lanes, one per bit position, each keep two running minima: one over the points whose bit is 0 and one over the points whose bit is 1.

A first flag on the stream restarts the minima, and a last flag closes the symbol. One cycle after the last point the core presents one LLR per bit, which is the bit-1 minimum minus the bit-0 minimum. The cost in cycles is one per constellation point, so QPSK up to 256-QAM and amplitude-phase rings are all handled by streaming a different point set. A per-axis mode splits the lanes between an I-only distance and a Q-only distance, so that a square constellation can be walked as two PAM axes.

Top module: `ml_soft_demap`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `llr_valid` is 0 and every LLR field is 0.
- R2: In joint mode (`mode_1d`=0) the distance is D = min(32767, floor(w·((y_I − floor(ρ_I·x_I/4096))² + (y_Q − floor(ρ_Q·x_Q/4096))²) / 65536)), where w is the unsigned `inv_var`.
- R3: For each active bit i, the output is sat16(min over points with label bit i = 1 of M_i, minus min over points with label bit i = 0 of M_i), where M_i is the lane metric. A bit value that no point carried counts as 524287. sat16 clamps to [−32768, 32767].
- R4: A point with `pt_first`=1 starts fresh minima, so no earlier symbol affects the result.
- R5: `llr_valid` is high exactly in the cycle after a cycle with `pt_valid`=1 and `pt_last`=1. A new symbol may start in that same cycle.
- R6: LLR fields for bit positions at or above `nbits` are 0, and label bits at those positions have no effect.
- R7: In joint mode with `iter_en`=1, M_i = D − Σ `apri`[j] over j ≠ i, j < `nbits`, where label bit j = 1. Each `apri` field is a signed 16-bit value, and lane j sits at bits [16j+15:16j].
- R8: With `iter_en`=0 the `apri` input has no effect, so M_i = D.
- R9: In per-axis mode (`mode_1d`=1), lanes i < `nbits`/2 (integer division) use the I-only distance and the other lanes use the Q-only distance. Each of these distances is saturated like D, and `apri` is not used.
- R10: The LLR outputs keep their value in every cycle in which `llr_valid` is 0.
- R11: Cycles with `pt_valid`=0 inside a symbol change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_valid | input | 1 | A constellation point is present |
| pt_first | input | 1 | The point is the first of a symbol |
| pt_last | input | 1 | The point is the last of a symbol |
| pt_i | input | 16 | Point in-phase coordinate, signed |
| pt_q | input | 16 | Point quadrature coordinate, signed |
| pt_label | input | 8 | Bit label of the point, bit i for lane i |
| rx_i | input | 16 | Received in-phase sample, signed |
| rx_q | input | 16 | Received quadrature sample, signed |
| fade_i | input | 16 | In-phase fading gain, signed, 4096 = 1.0 |
| fade_q | input | 16 | Quadrature fading gain, signed, 4096 = 1.0 |
| inv_var | input | 16 | Noise weight 1/(2σ²), unsigned, 65536 = 1.0 |
| mode_1d | input | 1 | 0 = joint distance, 1 = per-axis distances |
| iter_en | input | 1 | Apply a priori feedback |
| nbits | input | 4 | Bits per symbol, 1 to 8 |
| apri | input | 128 | Eight signed 16-bit a priori LLRs |
| llr_valid | output | 1 | One-cycle pulse: LLRs updated |
| llr | output | 128 | Eight signed 16-bit output LLRs |

## Verification
The bench targets several errors. Leaking minima across back-to-back symbols would corrupt the second symbol of a pair started directly after a last point. An extrinsic sum that forgot to drop the lane's own bit would shift every feedback result by that bit's LLR. Idle gaps inside a symbol would disturb the minima if the update ignored `pt_valid`. Label bits above `nbits` are set on purpose, and a mask that missed them would leak feedback or leave upper lanes nonzero. The bench also drives the rails: a saturated distance, extreme feedback that forces LLR clamping, a single-point symbol whose unseen bit value yields a clamped result, and per-axis mode with odd lane splits, where lanes on the wrong axis would show the wrong sign.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    typedef enum logic {
        DMP_JOINT = 1'b0,
        DMP_AXIS  = 1'b1
    } dmp_mode_e;

    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } dmp_pt_t;

    function automatic logic signed [63:0] dmp_clip(
        input logic signed [63:0] v,
        input logic signed [63:0] lo,
        input logic signed [63:0] hi
    );
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/dmp_dist.sv
module dmp_dist
    import dmp_pkg::*;
#(
    parameter int DW  = 16,
    parameter int RF  = 12,
    parameter int IVF = 16
) (
    input  logic signed [DW-1:0] rx_i,
    input  logic signed [DW-1:0] rx_q,
    input  logic signed [DW-1:0] fade_i,
    input  logic signed [DW-1:0] fade_q,
    input  logic signed [DW-1:0] pt_i,
    input  logic signed [DW-1:0] pt_q,
    input  logic        [DW-1:0] inv_var,
    output logic        [DW-1:0] d_joint,
    output logic        [DW-1:0] d_ax_i,
    output logic        [DW-1:0] d_ax_q
);
    localparam logic signed [63:0] DMAX = (64'sd1 <<< (DW - 1)) - 64'sd1;

    logic signed [63:0] err_i, err_q, sq_i, sq_q, wgt;

    always_comb begin
        err_i = 64'(rx_i) - ((64'(fade_i) * 64'(pt_i)) >>> RF);
        err_q = 64'(rx_q) - ((64'(fade_q) * 64'(pt_q)) >>> RF);
        sq_i  = err_i * err_i;
        sq_q  = err_q * err_q;
        wgt   = $signed({{(64 - DW){1'b0}}, inv_var});
        d_joint = DW'(dmp_clip(((sq_i + sq_q) * wgt) >>> IVF, 64'sd0, DMAX));
        d_ax_i  = DW'(dmp_clip((sq_i * wgt) >>> IVF, 64'sd0, DMAX));
        d_ax_q  = DW'(dmp_clip((sq_q * wgt) >>> IVF, 64'sd0, DMAX));
    end
endmodule

// File: rtl/dmp_apri.sv
module dmp_apri #(
    parameter int DW  = 16,
    parameter int NB  = 8,
    parameter int NBW = 4,
    parameter int MW  = 20
) (
    input  logic                   en,
    input  logic [NB-1:0]          label,
    input  logic [NBW-1:0]         nbits,
    input  logic [NB*DW-1:0]       apri,
    output logic [NB-1:0][MW-1:0]  ext
);
    logic signed [MW-1:0] total;
    logic signed [MW-1:0] own;

    always_comb begin
        total = '0;
        for (int j = 0; j < NB; j++) begin
            if (label[j] && (j < int'(nbits)))
                total = total + MW'($signed(apri[j*DW +: DW]));
        end
        own = '0;
        for (int i = 0; i < NB; i++) begin
            own = (label[i] && (i < int'(nbits))) ? MW'($signed(apri[i*DW +: DW])) : '0;
            ext[i] = en ? (total - own) : '0;
        end
    end
endmodule

// File: rtl/dmp_lane.sv
module dmp_lane
    import dmp_pkg::*;
#(
    parameter int DW = 16,
    parameter int MW = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pt_valid,
    input  logic                 first,
    input  logic                 bitv,
    input  logic                 lane_on,
    input  logic signed [MW-1:0] metric,
    output logic        [DW-1:0] llr_nx
);
    localparam logic signed [MW-1:0] MTOP = {1'b0, {(MW - 1){1'b1}}};
    localparam logic signed [63:0]   LO   = -(64'sd1 <<< (DW - 1));
    localparam logic signed [63:0]   HI   = (64'sd1 <<< (DW - 1)) - 64'sd1;

    logic signed [MW-1:0] min0, min1, st0, st1, nx0, nx1;

    always_comb begin
        st0 = first ? MTOP : min0;
        st1 = first ? MTOP : min1;
        nx0 = (!bitv && (metric < st0)) ? metric : st0;
        nx1 = (bitv && (metric < st1)) ? metric : st1;
        llr_nx = lane_on ? DW'(dmp_clip(64'(nx1) - 64'(nx0), LO, HI)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            min0 <= MTOP;
            min1 <= MTOP;
        end else if (pt_valid) begin
            min0 <= nx0;
            min1 <= nx1;
        end
    end
endmodule

// File: rtl/ml_soft_demap.sv
module ml_soft_demap
    import dmp_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NB  = 8,
    parameter int RF  = 12,
    parameter int IVF = 16,
    localparam int NBW = $clog2(NB + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pt_valid,
    input  logic                 pt_first,
    input  logic                 pt_last,
    input  logic signed [DW-1:0] pt_i,
    input  logic signed [DW-1:0] pt_q,
    input  logic [NB-1:0]        pt_label,
    input  logic signed [DW-1:0] rx_i,
    input  logic signed [DW-1:0] rx_q,
    input  logic signed [DW-1:0] fade_i,
    input  logic signed [DW-1:0] fade_q,
    input  logic [DW-1:0]        inv_var,
    input  logic                 mode_1d,
    input  logic                 iter_en,
    input  logic [NBW-1:0]       nbits,
    input  logic [NB*DW-1:0]     apri,
    output logic                 llr_valid,
    output logic [NB*DW-1:0]     llr
);
    localparam int MW = DW + $clog2(NB) + 1;

    dmp_mode_e            mode;
    dmp_pt_t              pt;
    logic [DW-1:0]        d_joint, d_ax_i, d_ax_q;
    logic [NB-1:0][MW-1:0] ext;
    logic [NB-1:0][DW-1:0] llr_nx;
    logic [NB*DW-1:0]     llr_q;
    logic                 vld_q;

    assign mode = mode_1d ? DMP_AXIS : DMP_JOINT;
    assign pt   = '{valid: pt_valid, first: pt_first, last: pt_last};

    dmp_dist #(.DW(DW), .RF(RF), .IVF(IVF)) u_dist (
        .rx_i(rx_i), .rx_q(rx_q), .fade_i(fade_i), .fade_q(fade_q),
        .pt_i(pt_i), .pt_q(pt_q), .inv_var(inv_var),
        .d_joint(d_joint), .d_ax_i(d_ax_i), .d_ax_q(d_ax_q)
    );

    dmp_apri #(.DW(DW), .NB(NB), .NBW(NBW), .MW(MW)) u_apri (
        .en(iter_en && (mode == DMP_JOINT)),
        .label(pt_label), .nbits(nbits), .apri(apri), .ext(ext)
    );

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic                 on, use_q;
        logic [DW-1:0]        dsel;
        logic signed [MW-1:0] metric;

        assign on    = NBW'(g) < nbits;
        assign use_q = NBW'(g) >= (nbits >> 1);

        always_comb begin
            if (mode == DMP_AXIS) dsel = use_q ? d_ax_q : d_ax_i;
            else                  dsel = d_joint;
            metric = $signed({{(MW - DW){1'b0}}, dsel}) - $signed(ext[g]);
        end

        dmp_lane #(.DW(DW), .MW(MW)) u_lane (
            .clk(clk), .rst(rst), .pt_valid(pt.valid), .first(pt.first),
            .bitv(pt_label[g]), .lane_on(on), .metric(metric), .llr_nx(llr_nx[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            llr_q <= '0;
        end else begin
            vld_q <= pt.valid && pt.last;
            if (pt.valid && pt.last) llr_q <= llr_nx;
        end
    end

    assign llr_valid = vld_q;
    assign llr       = llr_q;
endmodule

// File: rtl/dmp_chk.sv
module dmp_chk #(
    parameter int DW  = 16,
    parameter int NB  = 8,
    parameter int NBW = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               pt_valid,
    input logic               pt_last,
    input logic [NBW-1:0]     nbits,
    input logic               llr_valid,
    input logic [NB*DW-1:0]   llr
);
    logic [NBW-1:0] nb_cap;
    logic           upper_clean;

    always_ff @(posedge clk) begin
        if (rst) nb_cap <= '0;
        else if (pt_valid && pt_last) nb_cap <= nbits;
    end

    always_comb begin
        upper_clean = 1'b1;
        for (int i = 0; i < NB; i++)
            if ((i >= int'(nb_cap)) && (llr[i*DW +: DW] != '0)) upper_clean = 1'b0;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!llr_valid && (llr == '0)));

    p_pulse_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        (pt_valid && pt_last) |=> llr_valid);

    p_pulse_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
        llr_valid |-> $past(pt_valid && pt_last));

    p_upper_lanes_zero_r6: assert property (@(posedge clk) disable iff (rst)
        llr_valid |-> upper_clean);

    p_hold_between_r10: assert property (@(posedge clk) disable iff (rst)
        !llr_valid |-> $stable(llr));
endmodule

bind ml_soft_demap dmp_chk #(.DW(DW), .NB(NB), .NBW(NBW)) u_chk (
    .clk(clk), .rst(rst), .pt_valid(pt_valid), .pt_last(pt_last),
    .nbits(nbits), .llr_valid(llr_valid), .llr(llr)
);

// File: tb/sim_ml_soft_demap.sv
module sim_ml_soft_demap;
    localparam longint MTOP = 524287;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pt_valid = 1'b0, pt_first = 1'b0, pt_last = 1'b0;
    logic signed [15:0] pt_i = '0, pt_q = '0;
    logic [7:0]         pt_label = '0;
    logic signed [15:0] rx_i = '0, rx_q = '0, fade_i = 16'sd4096, fade_q = 16'sd4096;
    logic [15:0]        inv_var = '0;
    logic               mode_1d = 1'b0, iter_en = 1'b0;
    logic [3:0]         nbits = 4'd2;
    logic [127:0]       apri = '0;
    logic               llr_valid;
    logic [127:0]       llr;

    int     total = 0, bad = 0;
    string  cur_req = "R1";
    logic   exp_valid = 1'b0;
    longint exp_llr[8];
    longint mn0[8], mn1[8];

    always #10 clk = ~clk;

    ml_soft_demap u0 (
        .clk(clk), .rst(rst), .pt_valid(pt_valid), .pt_first(pt_first), .pt_last(pt_last),
        .pt_i(pt_i), .pt_q(pt_q), .pt_label(pt_label), .rx_i(rx_i), .rx_q(rx_q),
        .fade_i(fade_i), .fade_q(fade_q), .inv_var(inv_var), .mode_1d(mode_1d),
        .iter_en(iter_en), .nbits(nbits), .apri(apri), .llr_valid(llr_valid), .llr(llr)
    );

    function automatic longint cap(longint v);
        return (v > 32767) ? 32767 : v;
    endfunction

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_step();
        longint ei, eq, d2, di, dq, base, ext;
        int nb;
        if (rst) begin
            exp_valid = 1'b0;
            for (int i = 0; i < 8; i++) exp_llr[i] = 0;
            return;
        end
        exp_valid = pt_valid && pt_last;
        if (!pt_valid) return;
        nb = int'(nbits);
        ei = longint'(rx_i) - ((longint'(fade_i) * longint'(pt_i)) >>> 12);
        eq = longint'(rx_q) - ((longint'(fade_q) * longint'(pt_q)) >>> 12);
        d2 = cap(((ei * ei + eq * eq) * longint'(inv_var)) >>> 16);
        di = cap(((ei * ei) * longint'(inv_var)) >>> 16);
        dq = cap(((eq * eq) * longint'(inv_var)) >>> 16);
        for (int i = 0; i < 8; i++) begin
            if (mode_1d) base = (i >= nb / 2) ? dq : di;
            else         base = d2;
            ext = 0;
            if (iter_en && !mode_1d)
                for (int j = 0; j < nb; j++)
                    if (j != i && pt_label[j]) ext += longint'($signed(apri[j*16 +: 16]));
            if (pt_first) begin mn0[i] = MTOP; mn1[i] = MTOP; end
            if (pt_label[i]) begin if (base - ext < mn1[i]) mn1[i] = base - ext; end
            else             begin if (base - ext < mn0[i]) mn0[i] = base - ext; end
            if (pt_last) exp_llr[i] = (i < nb) ? sat16(mn1[i] - mn0[i]) : 0;
        end
    endtask

    task automatic compare();
        longint got;
        total++;
        if (llr_valid !== exp_valid) begin
            bad++;
            $display("FAIL R5 (%s) llr_valid actual=%b expected=%b", cur_req, llr_valid, exp_valid);
        end
        for (int i = 0; i < 8; i++) begin
            total++;
            got = longint'($signed(llr[i*16 +: 16]));
            if (got != exp_llr[i]) begin
                bad++;
                $display("FAIL %s lane %0d actual=%0d expected=%0d",
                         exp_valid ? cur_req : "R10", i, got, exp_llr[i]);
            end
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic put(int xi, int xq, int lab, bit f, bit l);
        pt_valid = 1'b1; pt_first = f; pt_last = l;
        pt_i = 16'(xi); pt_q = 16'(xq); pt_label = 8'(lab);
        tick();
    endtask

    task automatic idle(int n);
        pt_valid = 1'b0; pt_first = 1'b0; pt_last = 1'b0;
        repeat (n) tick();
    endtask

    task automatic cfg(int nb, bit m1, bit it, int yi, int yq, int fi, int fq, int w);
        nbits = 4'(nb); mode_1d = m1; iter_en = it;
        rx_i = 16'(yi); rx_q = 16'(yq); fade_i = 16'(fi); fade_q = 16'(fq); inv_var = 16'(w);
    endtask

    task automatic qpsk(int amp, int extra);
        for (int k = 0; k < 4; k++)
            put(k[0] ? -amp : amp, k[1] ? -amp : amp, k | extra, k == 0, k == 3);
    endtask

    task automatic qam(int side, int amp, int gap);
        int n;
        n = side * side;
        for (int k = 0; k < n; k++) begin
            put((2 * (k % side) - (side - 1)) * amp, (2 * (k / side) - (side - 1)) * amp,
                k, k == 0, k == n - 1);
            if (gap > 0 && (k % gap) == gap - 1 && k != n - 1) idle(2);
        end
    endtask

    task automatic psk8();
        int ci[8] = '{512, 362, 0, -362, -512, -362, 0, 362};
        int cq[8] = '{0, 362, 512, 362, 0, -362, -512, -362};
        for (int k = 0; k < 8; k++) put(ci[k], cq[k], k ^ (k >> 1), k == 0, k == 7);
    endtask

    task automatic pam4(int amp);
        for (int k = 0; k < 4; k++)
            put((2 * k - 3) * amp, (2 * k - 3) * amp, k | (k << 2), k == 0, k == 3);
    endtask

    task automatic set_apri(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
        apri = {16'(a7), 16'(a6), 16'(a5), 16'(a4), 16'(a3), 16'(a2), 16'(a1), 16'(a0)};
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin exp_llr[i] = 0; mn0[i] = MTOP; mn1[i] = MTOP; end
        cur_req = "R1";
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        idle(2);

        cur_req = "R2";
        cfg(2, 0, 0, 300, -200, 4096, 4096, 8192);
        qpsk(256, 0); idle(2);

        cur_req = "R3";
        cfg(4, 0, 0, -500, 700, 3500, 5000, 6000);
        qam(4, 256, 0); idle(1);

        cur_req = "R2";
        cfg(3, 0, 0, 100, 400, 2000, 6000, 9000);
        psk8(); idle(1);

        cur_req = "R7";
        set_apri(300, -450, 1200, -80, 999, -777, 555, 4444);
        cfg(4, 0, 1, -500, 700, 3500, 5000, 6000);
        qam(4, 256, 0); idle(1);

        cur_req = "R8";
        cfg(2, 0, 0, 300, -200, 4096, 4096, 8192);
        qpsk(256, 0); idle(1);

        cur_req = "R6";
        cfg(2, 0, 1, -150, 90, 4096, 4096, 8192);
        qpsk(256, 8'hF0); idle(1);

        cur_req = "R9";
        cfg(4, 1, 1, 350, -600, 4096, 3000, 7000);
        pam4(256); idle(1);
        cfg(3, 1, 0, -90, 420, 4096, 4096, 7000);
        pam4(200); idle(1);

        cur_req = "R11";
        cfg(4, 0, 0, 123, -321, 4096, 4096, 6000);
        qam(4, 256, 3); idle(1);

        cur_req = "R4";
        cfg(2, 0, 0, 256, 256, 4096, 4096, 8192);
        qpsk(256, 0);
        cfg(2, 0, 0, -900, 700, 4096, 4096, 8192);
        qpsk(256, 0); idle(2);

        cur_req = "R3";
        set_apri(32767, -32768, 32767, -32768, 0, 0, 0, 0);
        cfg(4, 0, 1, 10, -10, 4096, 4096, 6000);
        qam(4, 256, 0); idle(1);
        cfg(1, 0, 0, 40, 40, 4096, 4096, 6000);
        put(100, 100, 0, 1'b1, 1'b1); idle(1);

        cur_req = "R2";
        cfg(2, 0, 0, 32000, -32000, 4096, 4096, 65535);
        qpsk(256, 0); idle(1);
        set_apri(100, -200, 300, -400, 500, -600, 700, -800);
        cfg(8, 0, 1, 123, -456, 4096, 4096, 3000);
        qam(16, 64, 0); idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule